// File: doc/BRIEF.md
# Privileged Segment Address Decoder

This block sorts a 32-bit virtual address into one of five fixed windows of the privileged address map. Each window is either an unmapped direct window or one that goes through the TLB, and each window has its own privilege rule. The caller presents a request together with the privilege mode, the error-level bit, the access kind (load or store) and the result of an external TLB lookup for the same address. That TLB result must be valid in the same cycle as the request.

One cycle later the block returns the result:
- the physical address, or a fault code;
- the exception code that the fault raises;
- new values for three exception registers: the bad virtual address, the page-table context register and the TLB entry-high register.

The fault registers change only when a request faults. All outputs hold until the next valid request. The TLB array, extended 64-bit segments and the debug window belong to other blocks.

Top module: `seg_addr_decode`

## Requirements
- R1: After reset every output is zero.
- R2: An address at or below 0x7FFFFFFF with the error-level bit clear is mapped. It is open to all modes, and on a clean TLB result the physical address is the TLB-supplied address.
- R3: With the error-level bit set, an address at or below 0x7FFFFFFF is returned unchanged as the physical address, with no fault. The TLB result is ignored.
- R4: An address in 0x80000000..0x9FFFFFFF from kernel mode (mode 00) gives physical address = address - 0x80000000, without the TLB.
- R5: An address in 0xA0000000..0xBFFFFFFF from kernel mode gives physical address = address - 0xA0000000, without the TLB.
- R6: An address in 0xC0000000..0xDFFFFFFF is mapped. It is open to kernel (00) and supervisor (01) modes; user mode (10, and 11, which is treated as user) is refused.
- R7: An address at or above 0xE0000000 is mapped and open to kernel mode only.
- R8: A privilege refusal gives fault code 1. The exception code is 4 for a load and 5 for a store.
- R9: In a mapped window, a TLB miss gives fault code 2 and an entry that is not valid gives fault code 3. Both give exception code 2 for a load and 3 for a store.
- R10: A store to a valid entry whose dirty flag is clear gives fault code 4 and exception code 1. A load from that entry succeeds.
- R11: On a fault, the bad-address output takes the faulting address. The context output takes the incoming context with bits 22:4 replaced by address bits 31:13; its other bits are kept.
- R12: On a fault, the entry-high output is {address[31:13], 5'b0, asid}.
- R13: `rsp_valid` is high exactly one cycle after each valid request. A cycle with no request leaves every output except `rsp_valid` unchanged. A non-faulting request leaves the three exception-register outputs unchanged. A fault gives physical address 0, and no fault gives fault and exception code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe |
| req_vaddr | input | 32 | Virtual address |
| req_mode | input | 2 | 00 kernel, 01 supervisor, 10/11 user |
| req_store | input | 1 | 1 = store, 0 = load |
| err_level | input | 1 | Error-level status bit |
| cur_asid | input | 8 | Current address-space identifier |
| ctx_in | input | 32 | Present context register value |
| tlb_hit | input | 1 | TLB found a matching entry |
| tlb_valid | input | 1 | Matching page valid |
| tlb_dirty | input | 1 | Matching page writable |
| tlb_paddr | input | 32 | TLB-translated address |
| rsp_valid | output | 1 | Result strobe |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 3 | 0 none, 1 bad address, 2 miss, 3 invalid, 4 modify |
| rsp_exc | output | 5 | Exception code (0 none) |
| bad_vaddr | output | 32 | Faulting address |
| context_out | output | 32 | Updated context value |
| entryhi_out | output | 32 | Updated entry-high value |

## Verification
The embedded assertions check the following on every cycle:
- the one-cycle response timing;
- that the fault code and the exception code agree on whether a fault happened;
- that the bad-address and context outputs follow the faulting request;
- that idle cycles leave the exception registers untouched.

The window boundaries, the privilege decisions per mode, and the ordering of miss, invalid and modify faults depend on the particular address and TLB inputs. Only the bench's scenarios, compared against its reference model, can show those.

// File: rtl/seg_addr_decode.sv
module seg_addr_decode (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_vaddr,
  input  logic [1:0]  req_mode,
  input  logic        req_store,
  input  logic        err_level,
  input  logic [7:0]  cur_asid,
  input  logic [31:0] ctx_in,
  input  logic        tlb_hit,
  input  logic        tlb_valid,
  input  logic        tlb_dirty,
  input  logic [31:0] tlb_paddr,
  output logic        rsp_valid,
  output logic [31:0] rsp_paddr,
  output logic [2:0]  rsp_fault,
  output logic [4:0]  rsp_exc,
  output logic [31:0] bad_vaddr,
  output logic [31:0] context_out,
  output logic [31:0] entryhi_out
);

  localparam logic [2:0] F_NONE = 3'd0, F_BAD = 3'd1, F_MISS = 3'd2,
                         F_INV = 3'd3, F_MOD = 3'd4;

  logic is_kern, is_sup;
  assign is_kern = (req_mode == 2'b00);
  assign is_sup  = (req_mode == 2'b01);

  logic w_user, w_k0, w_k1, w_k2;
  assign w_user = ~req_vaddr[31];
  assign w_k0   = req_vaddr[31:29] == 3'b100;
  assign w_k1   = req_vaddr[31:29] == 3'b101;
  assign w_k2   = req_vaddr[31:29] == 3'b110;

  logic allowed, mapped;
  assign allowed = w_user | (w_k2 & (is_kern | is_sup)) | (~w_user & ~w_k2 & is_kern);
  assign mapped  = (w_user & ~err_level) | w_k2 | (req_vaddr[31:29] == 3'b111);

  logic [2:0]  fault_c;
  logic [31:0] paddr_c;
  always_comb begin
    fault_c = F_NONE;
    paddr_c = 32'd0;
    if (!allowed)                     fault_c = F_BAD;
    else if (mapped) begin
      if (!tlb_hit)                   fault_c = F_MISS;
      else if (!tlb_valid)            fault_c = F_INV;
      else if (req_store && !tlb_dirty) fault_c = F_MOD;
      else                            paddr_c = tlb_paddr;
    end
    else if (w_k0)                    paddr_c = req_vaddr - 32'h8000_0000;
    else if (w_k1)                    paddr_c = req_vaddr - 32'hA000_0000;
    else                              paddr_c = req_vaddr;
  end

  logic [4:0] exc_c;
  always_comb begin
    case (fault_c)
      F_BAD:         exc_c = req_store ? 5'd5 : 5'd4;
      F_MISS, F_INV: exc_c = req_store ? 5'd3 : 5'd2;
      F_MOD:         exc_c = 5'd1;
      default:       exc_c = 5'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_paddr   <= '0;
      rsp_fault   <= '0;
      rsp_exc     <= '0;
      bad_vaddr   <= '0;
      context_out <= '0;
      entryhi_out <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_paddr <= paddr_c;
        rsp_fault <= fault_c;
        rsp_exc   <= exc_c;
        if (fault_c != F_NONE) begin
          bad_vaddr   <= req_vaddr;
          context_out <= {ctx_in[31:23], req_vaddr[31:13], ctx_in[3:0]};
          entryhi_out <= {req_vaddr[31:13], 5'd0, cur_asid};
        end
      end
    end
  end

  // R13
  resp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(req_valid));

  // R8
  code_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_fault == 3'd0) == (rsp_exc == 5'd0)));

  // R11
  badaddr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 3'd0) |-> (bad_vaddr == $past(req_vaddr) &&
      context_out[3:0] == $past(ctx_in[3:0])));

  // R13
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> ($stable(bad_vaddr) && $stable(entryhi_out) && $stable(rsp_fault)));

  // R13
  fault_zero_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 3'd0) |-> rsp_paddr == 32'd0);

endmodule

// File: tb/tb_seg_addr_decode.sv
module tb_seg_addr_decode;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic        req_valid = 0, req_store = 0, err_level = 0;
  logic [31:0] req_vaddr = 0, ctx_in = 0, tlb_paddr = 0;
  logic [1:0]  req_mode = 0;
  logic [7:0]  cur_asid = 0;
  logic        tlb_hit = 0, tlb_valid = 0, tlb_dirty = 0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr, bad_vaddr, context_out, entryhi_out;
  logic [2:0]  rsp_fault;
  logic [4:0]  rsp_exc;

  seg_addr_decode dut (.*);

  integer checks = 0, errors = 0;
  logic [31:0] e_pa = 0, e_bva = 0, e_ctx = 0, e_eh = 0;
  integer e_f = 0, e_x = 0;
  logic e_v = 0;

  task automatic chk(input string r, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  task automatic compare(input string r);
    chk(r, "valid", {31'd0, rsp_valid}, {31'd0, e_v});
    chk(r, "paddr", rsp_paddr, e_pa);
    chk(r, "fault", {29'd0, rsp_fault}, e_f);
    chk(r, "exc", {27'd0, rsp_exc}, e_x);
    chk(r, "badvaddr", bad_vaddr, e_bva);
    chk(r, "context", context_out, e_ctx);
    chk(r, "entryhi", entryhi_out, e_eh);
  endtask

  task automatic model();
    longint unsigned a;
    integer f;
    longint unsigned pa;
    bit ok, map;
    a = req_vaddr; f = 0; pa = 0;
    if (a <= 64'h7FFF_FFFF) begin ok = 1; map = !err_level; end
    else if (a < 64'hC000_0000) begin ok = (req_mode == 0); map = 0; end
    else if (a < 64'hE000_0000) begin ok = (req_mode <= 1); map = 1; end
    else begin ok = (req_mode == 0); map = 1; end
    if (!ok) f = 1;
    else if (map) begin
      if (!tlb_hit) f = 2;
      else if (!tlb_valid) f = 3;
      else if (req_store && !tlb_dirty) f = 4;
      else pa = tlb_paddr;
    end else if (a >= 64'hA000_0000) pa = a - 64'hA000_0000;
    else if (a >= 64'h8000_0000) pa = a - 64'h8000_0000;
    else pa = a;
    e_v = req_valid;
    if (req_valid) begin
      e_f = f;
      e_pa = pa[31:0];
      case (f)
        1: e_x = req_store ? 5 : 4;
        2, 3: e_x = req_store ? 3 : 2;
        4: e_x = 1;
        default: e_x = 0;
      endcase
      if (f != 0) begin
        e_bva = req_vaddr;
        e_ctx = (ctx_in & 32'hFF80_000F) | ((req_vaddr >> 9) & 32'h007F_FFF0);
        e_eh = (req_vaddr & 32'hFFFF_E000) | cur_asid;
      end
    end
  endtask

  task automatic step(input string r, input logic v, input logic [31:0] va, input logic [1:0] m,
                      input logic st, input logic erl, input logic h, input logic vl,
                      input logic d, input logic [31:0] tp);
    req_valid = v; req_vaddr = va; req_mode = m; req_store = st; err_level = erl;
    tlb_hit = h; tlb_valid = vl; tlb_dirty = d; tlb_paddr = tp;
    model();
    @(negedge clk);
    compare(r);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cur_asid = 8'h5A; ctx_in = 32'hDEAD_BEEF;
    @(negedge clk); @(negedge clk);
    compare("R1");
    rst_n = 1;
    // R2 user mapped hit
    step("R2", 1, 32'h0040_1234, 2'b10, 0, 0, 1, 1, 0, 32'h1234_5000);
    step("R2", 1, 32'h7FFF_FFFF, 2'b00, 1, 0, 1, 1, 1, 32'h0ABC_D000);
    // R3 ERL identity, TLB ignored
    step("R3", 1, 32'h1234_5678, 2'b10, 1, 1, 0, 0, 0, 32'hFFFF_FFFF);
    // R4 / R5
    step("R4", 1, 32'h8000_0000, 2'b00, 0, 0, 0, 0, 0, 0);
    step("R4", 1, 32'h9FFF_FFFC, 2'b00, 1, 0, 0, 0, 0, 0);
    step("R5", 1, 32'hA000_0010, 2'b00, 0, 0, 0, 0, 0, 0);
    step("R5", 1, 32'hBFFF_FFFF, 2'b00, 0, 1, 0, 0, 0, 0);
    // R8 privilege refusals
    step("R8", 1, 32'h8000_1000, 2'b01, 0, 0, 1, 1, 1, 0);
    step("R8", 1, 32'hA123_4000, 2'b10, 1, 0, 1, 1, 1, 0);
    // R13 idle hold
    step("R13", 0, 32'h0000_0000, 2'b00, 0, 0, 0, 0, 0, 0);
    step("R13", 0, 32'h9000_0000, 2'b11, 1, 0, 0, 0, 0, 0);
    // R6
    step("R6", 1, 32'hC000_2000, 2'b01, 0, 0, 1, 1, 0, 32'h0777_7000);
    step("R6", 1, 32'hDFFF_E000, 2'b00, 1, 0, 1, 1, 1, 32'h0555_5000);
    step("R6", 1, 32'hC800_0000, 2'b10, 0, 0, 1, 1, 1, 0);
    step("R6", 1, 32'hC800_0000, 2'b11, 1, 0, 1, 1, 1, 0);
    // R7
    step("R7", 1, 32'hE000_0000, 2'b00, 0, 0, 1, 1, 0, 32'h0333_3000);
    step("R7", 1, 32'hFFFF_F000, 2'b01, 0, 0, 1, 1, 1, 0);
    // R13 non-fault keeps exception regs
    ctx_in = 32'h0123_4567; cur_asid = 8'h3C;
    step("R13", 1, 32'h8000_4000, 2'b00, 0, 0, 0, 0, 0, 0);
    // R9
    step("R9", 1, 32'h0001_0000, 2'b10, 0, 0, 0, 0, 0, 0);
    step("R9", 1, 32'h0001_0000, 2'b10, 1, 0, 0, 1, 1, 0);
    step("R9", 1, 32'hC123_4567, 2'b00, 0, 0, 1, 0, 1, 0);
    step("R9", 1, 32'hF000_0000, 2'b00, 1, 0, 1, 0, 0, 0);
    // R10
    step("R10", 1, 32'h2000_3000, 2'b10, 1, 0, 1, 1, 0, 32'h0999_9000);
    step("R10", 1, 32'h2000_3000, 2'b10, 0, 0, 1, 1, 0, 32'h0999_9000);
    // R11 / R12 distinct context and asid
    ctx_in = 32'hFFFF_FFFF; cur_asid = 8'hFF;
    step("R11", 1, 32'h8765_4321, 2'b10, 0, 0, 0, 0, 0, 0);
    ctx_in = 32'h0000_0000; cur_asid = 8'h01;
    step("R12", 1, 32'hFFFF_FFFF, 2'b01, 1, 0, 0, 0, 0, 0);
    step("R13", 0, 32'h0, 2'b00, 0, 0, 0, 0, 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule